// File: doc/BRIEF.md
# Cascaded Fixed-Point IIR Highpass Filter

This block is a fifth-order recursive highpass filter for a single stream of signed 16-bit samples. It is built from two second-order sections followed by one first-order section. Each second-order section is direct form II with two delay registers. The first-order section has one delay register. The whole cascade is evaluated in one clock cycle, and a clock enable marks which cycles carry a new sample.

The incoming sample is held in a capture register. The result is driven combinationally from the last section, so a sample shows up at the output right after the edge that captures it. Every point where a wide accumulator is cut back to sample width uses floor rounding and saturation.

All coefficients are elaboration-time parameters in a signed format with 14 fractional bits. The leading denominator coefficient of each section is taken as 1.

Top module: `iirhp_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the capture register and every delay register are cleared (synchronous, active high), so `dout` reads 0 after that edge.
- R2: When `en` is low at an edge, the capture register and all delay registers keep their values, so `dout` does not change whatever `din` does.
- R3: A sample on `din` with `en` high is captured at a rising edge, and its effect appears on `dout` straight after that same edge: one sample of latency and no output register.
- R4: The sections run in a fixed order: second-order section 0, then second-order section 1, then the first-order section. Each second-order section computes w = x − a1·w1 − a2·w2 and y = b0·w + b1·w1 + b2·w2. The first-order section computes w = x − a1·w1 and y = b0·w + b1·w1. Default coefficients in units of 2^-14 are as follows. Section 0: b = (4096, −8192, 4096), a = (−16384, 8192). Section 1: b = (8192, −16384, 8192), a = (−9830, 3277). First-order section: b = (8192, −8192), a1 = −8192.
- R5: Every product sum is formed without loss in an accumulator of at least 40 bits. It is cut to sample width by an arithmetic shift right of 14 bits, which rounds toward negative infinity (for example, −0.25 becomes −1).
- R6: A shifted value above 32767 becomes 32767, and one below −32768 becomes −32768. The sign never wraps. This applies to both the internal w value and the output of every section.
- R7: Delay registers advance only on enabled edges: w2 takes the old w1, and w1 takes the new w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; high marks a sample cycle |
| din | input | 16 | Signed input sample |
| dout | output | 16 | Signed filtered sample, combinational from the last section |

## Verification
The checks compare `dout` against a bit-accurate arithmetic model of the same equations.

- Impulse trains swept over amplitudes across the full signed range show the recursive tails and the section order.
- A −1 impulse separates floor rounding from rounding toward zero.
- Full-scale positive and negative steps push the first section's w past its range, which a wrapping narrower would turn into a sign flip.
- A ramp tests slow drift.
- A long pseudo-random run covers mixed signs.
- Stretches with `en` low and a changing `din` show that the output holds, and a reset in the middle of a run shows that all state is cleared.

// File: rtl/iirhp_pkg.sv
package iirhp_pkg;
  localparam int DATA_W    = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int ACC_W     = 40;
  localparam int N_SOS     = 2;
  typedef logic signed [DATA_W-1:0] sample_t;
endpackage

// File: rtl/iirhp_quant.sv
// Narrows a wide accumulator: floor via arithmetic shift, then saturate.
module iirhp_quant #(
  parameter int AW   = 40,
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [DW-1:0] q
);
  localparam int SW = AW - FRAC;
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [SW-1:0] sh;

  always_comb begin
    sh = acc[AW-1:FRAC];
    if (sh > MAXV)      q = {1'b0, {(DW-1){1'b1}}};
    else if (sh < MINV) q = {1'b1, {(DW-1){1'b0}}};
    else                q = sh[DW-1:0];
    // R6: narrowed result keeps the sign of the wide value
    assert_no_wrap_R6: assert (q[DW-1] == sh[SW-1]);
  end
endmodule

// File: rtl/iirhp_sos.sv
// Direct form II second-order section with two delay registers.
module iirhp_sos #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = 40,
  parameter int B0   = 0,
  parameter int B1   = 0,
  parameter int B2   = 0,
  parameter int A1   = 0,
  parameter int A2   = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);
  localparam logic signed [CW-1:0] CB0 = CW'(B0);
  localparam logic signed [CW-1:0] CB1 = CW'(B1);
  localparam logic signed [CW-1:0] CB2 = CW'(B2);
  localparam logic signed [CW-1:0] CA1 = CW'(A1);
  localparam logic signed [CW-1:0] CA2 = CW'(A2);
  localparam logic signed [AW-1:0] KB0 = AW'(CB0);
  localparam logic signed [AW-1:0] KB1 = AW'(CB1);
  localparam logic signed [AW-1:0] KB2 = AW'(CB2);
  localparam logic signed [AW-1:0] KA1 = AW'(CA1);
  localparam logic signed [AW-1:0] KA2 = AW'(CA2);

  logic signed [DW-1:0] w0, w1, w2;
  logic signed [AW-1:0] xe, w0e, w1e, w2e, acc_w, acc_y;

  always_comb begin
    xe    = AW'(x);
    w1e   = AW'(w1);
    w2e   = AW'(w2);
    acc_w = (xe <<< FRAC) - KA1 * w1e - KA2 * w2e;
  end

  iirhp_quant #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_qw (.acc(acc_w), .q(w0));

  always_comb begin
    w0e   = AW'(w0);
    acc_y = KB0 * w0e + KB1 * w1e + KB2 * w2e;
  end

  iirhp_quant #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_qy (.acc(acc_y), .q(y));

  always_ff @(posedge clk) begin
    if (rst) begin
      w1 <= '0;
      w2 <= '0;
    end else if (en) begin
      w1 <= w0;
      w2 <= w1;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(w1) && $stable(w2)));
  assert_shift_R7: assert property (@(posedge clk) disable iff (rst)
    en |=> (w2 == $past(w1)));
  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (w1 == '0 && w2 == '0));
endmodule

// File: rtl/iirhp_fos.sv
// First-order section with one delay register.
module iirhp_fos #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = 40,
  parameter int B0   = 0,
  parameter int B1   = 0,
  parameter int A1   = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);
  localparam logic signed [CW-1:0] CB0 = CW'(B0);
  localparam logic signed [CW-1:0] CB1 = CW'(B1);
  localparam logic signed [CW-1:0] CA1 = CW'(A1);
  localparam logic signed [AW-1:0] KB0 = AW'(CB0);
  localparam logic signed [AW-1:0] KB1 = AW'(CB1);
  localparam logic signed [AW-1:0] KA1 = AW'(CA1);

  logic signed [DW-1:0] w0, w1;
  logic signed [AW-1:0] xe, w0e, w1e, acc_w, acc_y;

  always_comb begin
    xe    = AW'(x);
    w1e   = AW'(w1);
    acc_w = (xe <<< FRAC) - KA1 * w1e;
  end

  iirhp_quant #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_qw (.acc(acc_w), .q(w0));

  always_comb begin
    w0e   = AW'(w0);
    acc_y = KB0 * w0e + KB1 * w1e;
  end

  iirhp_quant #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_qy (.acc(acc_y), .q(y));

  always_ff @(posedge clk) begin
    if (rst)     w1 <= '0;
    else if (en) w1 <= w0;
  end

  assert_fos_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(w1));
  assert_fos_clear_R1: assert property (@(posedge clk)
    rst |=> (w1 == '0));
endmodule

// File: rtl/iirhp_top.sv
module iirhp_top
  import iirhp_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int CW   = COEF_W,
  parameter int FRAC = COEF_FRAC,
  parameter int AW   = ACC_W,
  parameter int NSOS = N_SOS,
  parameter int SOS_B0 [NSOS] = '{4096, 8192},
  parameter int SOS_B1 [NSOS] = '{-8192, -16384},
  parameter int SOS_B2 [NSOS] = '{4096, 8192},
  parameter int SOS_A1 [NSOS] = '{-16384, -9830},
  parameter int SOS_A2 [NSOS] = '{8192, 3277},
  parameter int FOS_B0 = 8192,
  parameter int FOS_B1 = -8192,
  parameter int FOS_A1 = -8192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  logic signed [DW-1:0] x_q;
  logic signed [DW-1:0] stage [NSOS+1];

  always_ff @(posedge clk) begin
    if (rst)     x_q <= '0;
    else if (en) x_q <= din;
  end

  assign stage[0] = x_q;

  for (genvar g = 0; g < NSOS; g++) begin : g_sos
    iirhp_sos #(
      .DW(DW), .CW(CW), .FRAC(FRAC), .AW(AW),
      .B0(SOS_B0[g]), .B1(SOS_B1[g]), .B2(SOS_B2[g]),
      .A1(SOS_A1[g]), .A2(SOS_A2[g])
    ) u_sos (
      .clk(clk), .rst(rst), .en(en), .x(stage[g]), .y(stage[g+1])
    );
  end

  iirhp_fos #(
    .DW(DW), .CW(CW), .FRAC(FRAC), .AW(AW),
    .B0(FOS_B0), .B1(FOS_B1), .A1(FOS_A1)
  ) u_fos (
    .clk(clk), .rst(rst), .en(en), .x(stage[NSOS]), .y(dout)
  );

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (x_q == $past(din)));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (x_q == '0));
  assert_hold_in_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(x_q));
endmodule

// File: tb/iirhp_top_tb.sv
module iirhp_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [15:0] din = '0;
  logic signed [15:0] dout;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  iirhp_top u_dut (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout));

  always #4 clk = ~clk;

  // Model coefficients, units of 2^-14 (R4)
  longint B0 [2] = '{4096, 8192};
  longint B1 [2] = '{-8192, -16384};
  longint B2 [2] = '{4096, 8192};
  longint A1 [2] = '{-16384, -9830};
  longint A2 [2] = '{8192, 3277};
  longint FB0 = 8192, FB1 = -8192, FA1 = -8192;

  longint m_w1 [2];
  longint m_w2 [2];
  longint m_f1, m_xq, expv;

  // Floor (R5) then saturate (R6)
  function automatic longint qz(input longint a);
    longint s;
    s = a >>> 14;
    if (s > 32767)  return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_w1[i] = 0;
      m_w2[i] = 0;
    end
    m_f1 = 0;
    m_xq = 0;
  endtask

  task automatic model_eval(input bit upd, output longint y);
    longint s, w0;
    s = m_xq;
    for (int i = 0; i < 2; i++) begin
      w0 = qz(s * 16384 - A1[i] * m_w1[i] - A2[i] * m_w2[i]);
      s  = qz(B0[i] * w0 + B1[i] * m_w1[i] + B2[i] * m_w2[i]);
      if (upd) begin
        m_w2[i] = m_w1[i];
        m_w1[i] = w0;
      end
    end
    w0 = qz(s * 16384 - FA1 * m_f1);
    s  = qz(FB0 * w0 + FB1 * m_f1);
    if (upd) m_f1 = w0;
    y = s;
  endtask

  task automatic check(input string req, input longint exp_v);
    vectors++;
    if (longint'(dout) != exp_v) begin
      fails++;
      $display("FAIL %s: dout=%0d expected=%0d", req, dout, exp_v);
    end
  endtask

  // Drive at negedge, let the edge act, sample 2 ns after the edge.
  task automatic step_in(input longint v, input bit e, input string req);
    longint dummy;
    @(negedge clk);
    din = 16'(v);
    en  = e;
    @(posedge clk);
    if (e) begin
      model_eval(1'b1, dummy);
      m_xq = longint'($signed(16'(v)));
    end
    #2;
    model_eval(1'b0, expv);
    check(req, expv);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    din = 16'sd12345;
    @(posedge clk);
    @(posedge clk);
    #2;
    model_reset();
    check(req, 0);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    longint held;
    model_reset();
    do_reset("R1 reset state");

    // R3: one-sample latency, first output right after capture
    step_in(16384, 1'b1, "R3 impulse latency");
    vectors++;
    if (dout == 0) begin
      fails++;
      $display("FAIL R3: dout=0 expected nonzero right after capture");
    end
    for (int k = 0; k < 30; k++) step_in(0, 1'b1, "R4 impulse tail");

    // R4 / R7: impulse amplitude sweep across the signed range
    for (int a = -32768; a <= 32767; a += 4099) begin
      do_reset("R1 reset between impulses");
      step_in(a, 1'b1, "R4 impulse sweep head");
      for (int k = 0; k < 24; k++) step_in(0, 1'b1, "R7 impulse sweep tail");
    end

    // R5: -1 impulse, floor rounding gives -1 where rounding toward zero gives 0
    do_reset("R1 reset");
    step_in(-1, 1'b1, "R5 floor negative impulse");
    vectors++;
    if (dout != -16'sd1) begin
      fails++;
      $display("FAIL R5: dout=%0d expected=-1", dout);
    end
    for (int k = 0; k < 16; k++) step_in(0, 1'b1, "R5 floor tail");

    // R6: full-scale steps saturate internally
    do_reset("R1 reset");
    for (int k = 0; k < 60; k++) step_in(32767, 1'b1, "R6 positive full-scale step");
    do_reset("R1 reset");
    for (int k = 0; k < 60; k++) step_in(-32768, 1'b1, "R6 negative full-scale step");
    for (int k = 0; k < 40; k++) step_in(32767, 1'b1, "R6 step reversal");

    // Ramp
    do_reset("R1 reset");
    for (int k = 0; k < 200; k++) step_in(-25000 + k * 250, 1'b1, "R4 ramp");

    // Pseudo-random, with enable-low holds interleaved (R2)
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 97 == 50) begin
        held = longint'(dout);
        for (int h = 0; h < 5; h++) begin
          step_in(longint'($signed(lfsr ^ 16'(h * 7919))), 1'b0, "R2 enable low hold");
          vectors++;
          if (longint'(dout) != held) begin
            fails++;
            $display("FAIL R2: dout=%0d expected=%0d", dout, held);
          end
        end
      end
      step_in(longint'($signed(lfsr)), 1'b1, "R6 pseudo-random");
    end

    // R1: reset in the middle of activity
    do_reset("R1 mid-run reset");
    step_in(0, 1'b1, "R1 zero after reset");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule